// File: doc/BRIEF.md
# Type-C Port Attach Controller

This block decides when a USB Type-C port has a partner and what kind of partner it is. It takes a per-pin classification of the voltage seen on each of the two configuration pins, plus a flag for VBUS being present. From these it walks a single state machine through the unattached, waiting, trial and attached states. The comparators, terminations and current sources sit outside the block. The block only turns their coded results into a connection decision.

The port can be built into a product as a sink only, a source only, or a dual-role port. A dual-role port swaps between presenting sink and source terminations until something connects. A dual-role port can also be told to prefer one role. It then takes a short trial in the preferred role before settling, and falls back to a wait state if the trial finds nothing. When the port acts as a source, it can also recognise audio and debug accessories.

All time limits are counted in clock cycles: two debounce lengths, a trial timeout and the toggle half-period. Every debounce restarts as soon as the condition it qualifies changes.

Top module: `tcc_attach_fsm`

## Requirements
- R1: After reset the state output is 0 (sink unattached), orientation, port type, current and event are 0, and `src_n` is 1. State codes: 0 sink unattached, 1 source unattached, 2 sink wait, 3 source wait, 4 sink attached, 5 source attached, 6 trial as source, 7 trial as sink, 8 sink trial-wait, 9 source trial-wait, 10 audio accessory, 11 debug accessory.
- R2: `role_sel` selects the role: 0 sink, 1 source, 2 or 3 dual-role. A dual-role port that sees nothing alternates between states 0 and 1, spending TOGGLE cycles in each. A sink port stays in state 0. A source port moves to state 1 one cycle after reset. Only a port that is not a sink enters state 5.
- R3: Pin codes are: 0 open, 1 sink termination, 2 audio/cable termination, 3 source at default current, 4 source at 1.5 A, 5 source at 3.0 A. State 0 moves to state 2 when either pin shows code 3 to 5. State 1 moves to state 3 when either pin shows code 1 or 2. State 3 returns to unattached the cycle after both pins read open.
- R4: State 2 enters state 4 once exactly one pin has shown a source code, with the other pin open, for CC_DBC consecutive cycles and `vbus_ok` is high. State 4 drops to state 0 the cycle after `vbus_ok` falls. In state 4 the port type is 2.
- R5: State 3 enters state 5 after exactly one pin has shown code 1 for CC_DBC consecutive cycles. State 5 returns to unattached the cycle after neither pin shows code 1. In state 5 the port type is 1.
- R6: When `acc_en` is 1, both pins at code 2 for CC_DBC cycles lead from state 3 to state 10 (port type 3). Both pins at code 1 for CC_DBC cycles lead to state 11 (port type 4). Each accessory state exits when its termination is gone from both pins. When `acc_en` is 0, both pins at code 1 leave the port in state 3.
- R7: With `try_sel` 2 on a dual-role port, a qualified source in state 2 leads to state 6. A sink seen there for PD_DBC cycles gives state 5. With no sink after TRY_TMO cycles the port goes to state 8. A source with VBUS held there for CC_DBC cycles gives state 4.
- R8: With `try_sel` 1 on a dual-role port, a qualified sink in state 3 leads to state 7. A source with VBUS seen there for PD_DBC cycles gives state 4. With none after TRY_TMO cycles the port goes to state 9. In state 9, a sink held for PD_DBC cycles gives state 5, and PD_DBC cycles without a sink give state 0.
- R9: Any change of the pin classification restarts the running debounce from zero.
- R10: In state 4, `curr_lvl` follows the source pin's code, updating within the same cycle: 1 for default current, 2 for 1.5 A, 3 for 3.0 A. It is 0 in every other state.
- R11: `orient` is 1 when only CC1 is active, 2 when only CC2 is active, 3 when both are active, and 0 when no partner is attached.
- R12: `src_n` is low exactly while the port is attached as a source (state 5).
- R13: `evt` pulses 1 for the first cycle after entering states 4, 5, 10 or 11. It pulses 2 for the first cycle after leaving them. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cc1_lvl | input | 3 | Classification code for CC1 |
| cc2_lvl | input | 3 | Classification code for CC2 |
| vbus_ok | input | 1 | VBUS above detection threshold |
| role_sel | input | 2 | Port role |
| try_sel | input | 2 | Role preference for dual-role |
| acc_en | input | 1 | Accessory detection enable |
| state | output | 4 | Current state code |
| orient | output | 2 | Plug orientation |
| port_type | output | 3 | Attached partner type |
| curr_lvl | output | 2 | Detected source current |
| evt | output | 2 | Attach/detach pulse |
| src_n | output | 1 | Open-drain style source indication, low active |

## Verification
The assertions check, on every cycle, the relations between outputs:
- a sink attach is only entered with VBUS present, and VBUS loss ends it;
- a source attach is never entered by a sink-only port;
- the event code agrees with the port type;
- current is reported only when attached as a sink;
- orientation is standby whenever nothing is attached.

The exact debounce lengths can only be shown by the bench scenarios, which sample the cycle just before and the cycle of each transition. The same holds for:
- the restart of a debounce after a glitch;
- the toggle period;
- the trial timeouts and their fallback paths;
- the accessory enable.

// File: rtl/tcc_attach_fsm.sv
module tcc_attach_fsm #(
  parameter int CC_DBC  = 100000,
  parameter int PD_DBC  = 10000,
  parameter int TRY_TMO = 75000,
  parameter int TOGGLE  = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cc1_lvl,
  input  logic [2:0] cc2_lvl,
  input  logic       vbus_ok,
  input  logic [1:0] role_sel,
  input  logic [1:0] try_sel,
  input  logic       acc_en,
  output logic [3:0] state,
  output logic [1:0] orient,
  output logic [2:0] port_type,
  output logic [1:0] curr_lvl,
  output logic [1:0] evt,
  output logic       src_n
);
  localparam int MX_A = (CC_DBC > PD_DBC) ? CC_DBC : PD_DBC;
  localparam int MX_B = (TRY_TMO > TOGGLE) ? TRY_TMO : TOGGLE;
  localparam int MX   = (MX_A > MX_B) ? MX_A : MX_B;
  localparam int CW   = $clog2(MX + 1) + 1;
  localparam logic [CW-1:0] LIM_CC  = CW'(CC_DBC - 1);
  localparam logic [CW-1:0] LIM_PD  = CW'(PD_DBC - 1);
  localparam logic [CW-1:0] LIM_TRY = CW'(TRY_TMO - 1);
  localparam logic [CW-1:0] LIM_TOG = CW'(TOGGLE - 1);

  localparam logic [3:0] S_USNK = 4'd0,  S_USRC = 4'd1,  S_WSNK = 4'd2,  S_WSRC = 4'd3;
  localparam logic [3:0] S_ASNK = 4'd4,  S_ASRC = 4'd5,  S_TSRC = 4'd6,  S_TSNK = 4'd7;
  localparam logic [3:0] S_TWSNK = 4'd8, S_TWSRC = 4'd9, S_AUD = 4'd10,  S_DBG = 4'd11;

  localparam logic [2:0] C_NONE = 3'd0, C_SNK = 3'd1, C_SRC = 3'd2, C_AUD = 3'd3, C_DBG = 3'd4, C_OTH = 3'd5;

  logic [3:0] st, st_q, nxt;
  logic [2:0] cls, cls_q;
  logic [CW-1:0] run, tm, eff, tcnt;

  wire rd1 = cc1_lvl == 3'd1;
  wire rd2 = cc2_lvl == 3'd1;
  wire ra1 = cc1_lvl == 3'd2;
  wire ra2 = cc2_lvl == 3'd2;
  wire sl1 = cc1_lvl >= 3'd3 && cc1_lvl <= 3'd5;
  wire sl2 = cc2_lvl >= 3'd3 && cc2_lvl <= 3'd5;
  wire op1 = cc1_lvl == 3'd0;
  wire op2 = cc2_lvl == 3'd0;

  wire is_snk  = role_sel == 2'd0;
  wire is_src  = role_sel == 2'd1;
  wire is_drp  = role_sel[1];
  wire pref_src = is_drp && try_sel == 2'd2;
  wire pref_snk = is_drp && try_sel == 2'd1;
  wire [3:0] home = is_src ? S_USRC : S_USNK;

  always_comb begin
    if ((sl1 && op2) || (sl2 && op1))          cls = C_SRC;
    else if ((rd1 ^ rd2) && !sl1 && !sl2)      cls = C_SNK;
    else if (ra1 && ra2)                       cls = C_AUD;
    else if (rd1 && rd2)                       cls = C_DBG;
    else if (op1 && op2)                       cls = C_NONE;
    else                                       cls = C_OTH;
  end

  wire same_st = st == st_q;
  assign eff  = (same_st && cls == cls_q) ? run : '0;
  assign tcnt = same_st ? tm : '0;
  wire cc_ok  = eff >= LIM_CC;
  wire pd_ok  = eff >= LIM_PD;

  function automatic logic attached(input logic [3:0] s);
    return s == S_ASNK || s == S_ASRC || s == S_AUD || s == S_DBG;
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      S_USNK:
        if (is_src)                          nxt = S_USRC;
        else if (sl1 || sl2)                 nxt = S_WSNK;
        else if (is_drp && tcnt >= LIM_TOG)  nxt = S_USRC;
      S_USRC:
        if (is_snk)                          nxt = S_USNK;
        else if (rd1 || rd2 || ra1 || ra2)   nxt = S_WSRC;
        else if (is_drp && tcnt >= LIM_TOG)  nxt = S_USNK;
      S_WSNK:
        if (!sl1 && !sl2)                    nxt = S_USNK;
        else if (cls == C_SRC && cc_ok && vbus_ok) nxt = pref_src ? S_TSRC : S_ASNK;
      S_ASNK:
        if (!vbus_ok)                        nxt = S_USNK;
      S_WSRC:
        if (cls == C_NONE)                   nxt = home;
        else if (cls == C_SNK && cc_ok)      nxt = pref_snk ? S_TSNK : S_ASRC;
        else if (acc_en && cls == C_AUD && cc_ok) nxt = S_AUD;
        else if (acc_en && cls == C_DBG && cc_ok) nxt = S_DBG;
      S_ASRC:
        if (!rd1 && !rd2)                    nxt = home;
      S_AUD:
        if (!ra1 && !ra2)                    nxt = home;
      S_DBG:
        if (!rd1 && !rd2)                    nxt = home;
      S_TSRC:
        if (cls == C_SNK && pd_ok)           nxt = S_ASRC;
        else if (tcnt >= LIM_TRY)            nxt = S_TWSNK;
      S_TWSNK:
        if (cls == C_SRC && cc_ok && vbus_ok) nxt = S_ASNK;
        else if (cls == C_NONE && pd_ok)     nxt = S_USNK;
      S_TSNK:
        if (cls == C_SRC && pd_ok && vbus_ok) nxt = S_ASNK;
        else if (tcnt >= LIM_TRY)            nxt = S_TWSRC;
      S_TWSRC:
        if (cls == C_SNK && pd_ok)           nxt = S_ASRC;
        else if (pd_ok)                      nxt = S_USNK;
      default:                               nxt = S_USNK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_USNK;
      st_q  <= S_USNK;
      cls_q <= C_NONE;
      run   <= '0;
      tm    <= '0;
      evt   <= 2'b00;
    end else begin
      st    <= nxt;
      st_q  <= st;
      cls_q <= cls;
      run   <= (&eff) ? eff : eff + 1'b1;
      tm    <= (&tcnt) ? tcnt : tcnt + 1'b1;
      if (attached(nxt) && !attached(st))      evt <= 2'b01;
      else if (!attached(nxt) && attached(st)) evt <= 2'b10;
      else                                     evt <= 2'b00;
    end
  end

  wire [2:0] lv = sl1 ? cc1_lvl : cc2_lvl;

  always_comb begin
    orient    = 2'b00;
    port_type = 3'd0;
    curr_lvl  = 2'b00;
    case (st)
      S_ASNK: begin
        orient    = {sl2, sl1};
        port_type = 3'd2;
        curr_lvl  = (sl1 || sl2) ? 2'(lv - 3'd2) : 2'b00;
      end
      S_ASRC: begin
        orient    = {rd2, rd1};
        port_type = 3'd1;
      end
      S_AUD: begin
        orient    = {!op2, !op1};
        port_type = 3'd3;
      end
      S_DBG: begin
        orient    = {!op2, !op1};
        port_type = 3'd4;
      end
      default: ;
    endcase
  end

  assign state = st;
  assign src_n = st != S_ASRC;
endmodule

// File: rtl/tcc_attach_chk.sv
module tcc_attach_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vbus_ok,
  input logic [1:0] role_sel,
  input logic [3:0] state,
  input logic [1:0] orient,
  input logic [2:0] port_type,
  input logic [1:0] curr_lvl,
  input logic [1:0] evt,
  input logic       src_n
);
  p_snk_entry_vbus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd4 && $past(state) != 4'd4) |-> $past(vbus_ok));

  p_vbus_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 4'd4 && !$past(vbus_ok)) |-> state == 4'd0);

  p_src_entry_role_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd5 && $past(state) != 4'd5) |-> $past(role_sel) != 2'd0);

  p_evt_attach_r13: assert property (@(posedge clk) disable iff (!rst_n)
    evt == 2'b01 |-> port_type != 3'd0);

  p_evt_detach_r13: assert property (@(posedge clk) disable iff (!rst_n)
    evt == 2'b10 |-> port_type == 3'd0);

  p_srcind_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !src_n |-> port_type == 3'd1);

  p_curr_only_snk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    curr_lvl != 2'b00 |-> port_type == 3'd2);

  p_orient_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    port_type == 3'd0 |-> orient == 2'b00);
endmodule

bind tcc_attach_fsm tcc_attach_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vbus_ok(vbus_ok), .role_sel(role_sel),
  .state(state), .orient(orient), .port_type(port_type),
  .curr_lvl(curr_lvl), .evt(evt), .src_n(src_n)
);

// File: tb/sim_tcc_attach_fsm.sv
module sim_tcc_attach_fsm;
  localparam int LCC = 20, LPD = 5, LTRY = 40, LTOG = 30;
  localparam int W_ST = 0, W_OR = 1, W_PT = 2, W_CU = 3, W_EV = 4, W_SN = 5;

  logic clk = 0, rst_n = 0;
  logic [2:0] cc1 = 0, cc2 = 0;
  logic vbus = 0, acc = 0;
  logic [1:0] role = 0, tsel = 0;
  logic [3:0] state;
  logic [1:0] orient, curr_lvl, evt;
  logic [2:0] port_type;
  logic src_n;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int at; int what; int val; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tcc_attach_fsm #(.CC_DBC(LCC), .PD_DBC(LPD), .TRY_TMO(LTRY), .TOGGLE(LTOG)) u0 (
    .clk(clk), .rst_n(rst_n), .cc1_lvl(cc1), .cc2_lvl(cc2), .vbus_ok(vbus),
    .role_sel(role), .try_sel(tsel), .acc_en(acc), .state(state), .orient(orient),
    .port_type(port_type), .curr_lvl(curr_lvl), .evt(evt), .src_n(src_n));

  function automatic int actual(input int w);
    case (w)
      W_ST: return int'(state);
      W_OR: return int'(orient);
      W_PT: return int'(port_type);
      W_CU: return int'(curr_lvl);
      W_EV: return int'(evt);
      default: return int'(src_n);
    endcase
  endfunction

  always @(negedge clk) begin
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at <= cyc) begin
        checks++;
        if (actual(q[i].what) != q[i].val) begin
          errors++;
          $display("FAIL %s sel %0d cycle %0d actual %0d expected %0d",
                   q[i].tag, q[i].what, q[i].at, actual(q[i].what), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(input int at, input int what, input int val, input string tag);
    item_t it;
    it.at = at; it.what = what; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] r, input logic [1:0] t, input logic a, output int c0);
    @(negedge clk);
    rst_n = 0; role = r; tsel = t; acc = a; cc1 = 0; cc2 = 0; vbus = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    c0 = cyc;
  endtask

  initial begin
    int c0, c, k, k2;

    // R1, R2: reset state and dual-role toggling
    do_reset(2'd2, 2'd0, 1'b0, c0);
    expect_at(c0, W_ST, 0, "R1 state");
    expect_at(c0, W_SN, 1, "R1 src_n");
    expect_at(c0, W_EV, 0, "R1 evt");
    expect_at(c0, W_PT, 0, "R1 port");
    expect_at(c0, W_OR, 0, "R1 orient");
    expect_at(c0, W_CU, 0, "R1 curr");
    expect_at(c0 + LTOG - 1, W_ST, 0, "R2 toggle early");
    expect_at(c0 + LTOG, W_ST, 1, "R2 toggle to source");
    expect_at(c0 + 2*LTOG - 1, W_ST, 1, "R2 toggle hold");
    expect_at(c0 + 2*LTOG, W_ST, 0, "R2 toggle back");
    drain();

    // R2: sink-only port stays unattached sink
    do_reset(2'd0, 2'd0, 1'b0, c0);
    expect_at(c0 + LTOG + 5, W_ST, 0, "R2 sink stays");
    drain();

    // R2, R3, R5, R11, R12, R13: source attach and detach
    do_reset(2'd1, 2'd0, 1'b0, c0);
    expect_at(c0 + 1, W_ST, 1, "R2 source role");
    wait_until(c0 + 3);
    c = cyc; cc1 = 3'd1;
    expect_at(c + 1, W_ST, 3, "R3 wait src");
    expect_at(c + LCC, W_ST, 3, "R5 before debounce");
    expect_at(c + LCC + 1, W_ST, 5, "R5 attached src");
    expect_at(c + LCC + 1, W_EV, 1, "R13 attach pulse");
    expect_at(c + LCC + 2, W_EV, 0, "R13 pulse one cycle");
    expect_at(c + LCC + 1, W_SN, 0, "R12 src_n low");
    expect_at(c + LCC + 1, W_OR, 1, "R11 orient cc1");
    expect_at(c + LCC + 1, W_PT, 1, "R5 port sink");
    wait_until(c + LCC + 4);
    c = cyc; cc1 = 3'd0;
    expect_at(c + 1, W_ST, 1, "R5 sink removed");
    expect_at(c + 1, W_EV, 2, "R13 detach pulse");
    expect_at(c + 1, W_SN, 1, "R12 src_n released");
    wait_until(c + 3);
    c = cyc; cc2 = 3'd1;
    expect_at(c + 1, W_ST, 3, "R3 wait again");
    wait_until(c + 3);
    c = cyc; cc2 = 3'd0;
    expect_at(c + 1, W_ST, 1, "R3 removal in wait");
    drain();

    // R9: debounce restarts after a glitch
    do_reset(2'd1, 2'd0, 1'b0, c0);
    wait_until(c0 + 3);
    c = cyc; cc1 = 3'd1;
    wait_until(c + 5); cc1 = 3'd2;
    wait_until(c + 6); cc1 = 3'd1;
    expect_at(c + 1 + LCC, W_ST, 3, "R9 no early attach");
    expect_at(c + 5 + LCC, W_ST, 3, "R9 restarted");
    expect_at(c + 6 + LCC, W_ST, 5, "R9 attach after restart");
    drain();

    // R4, R10, R11, R13: sink attach, current, VBUS loss
    do_reset(2'd0, 2'd0, 1'b0, c0);
    wait_until(c0 + 2);
    c = cyc; cc2 = 3'd4;
    expect_at(c + 1, W_ST, 2, "R3 wait snk");
    expect_at(c + LCC + 3, W_ST, 2, "R4 no vbus no attach");
    wait_until(c + LCC + 4);
    c = cyc; vbus = 1;
    expect_at(c + 1, W_ST, 4, "R4 attached snk");
    expect_at(c + 1, W_EV, 1, "R13 attach snk");
    expect_at(c + 1, W_CU, 2, "R10 1.5A");
    expect_at(c + 1, W_OR, 2, "R11 orient cc2");
    expect_at(c + 1, W_PT, 2, "R4 port source");
    wait_until(c + 3); cc2 = 3'd5;
    expect_at(c + 3, W_CU, 3, "R10 3.0A");
    wait_until(c + 4); cc2 = 3'd3;
    expect_at(c + 4, W_CU, 1, "R10 default");
    wait_until(c + 6); vbus = 0;
    expect_at(c + 7, W_ST, 0, "R4 vbus loss");
    expect_at(c + 7, W_EV, 2, "R13 detach snk");
    expect_at(c + 7, W_CU, 0, "R10 idle");
    drain();

    // R6: accessories
    do_reset(2'd1, 2'd0, 1'b1, c0);
    wait_until(c0 + 3);
    c = cyc; cc1 = 3'd2; cc2 = 3'd2;
    expect_at(c + LCC, W_ST, 3, "R6 audio early");
    expect_at(c + LCC + 1, W_ST, 10, "R6 audio");
    expect_at(c + LCC + 1, W_PT, 3, "R6 audio port");
    expect_at(c + LCC + 1, W_OR, 3, "R11 both pins");
    wait_until(c + LCC + 4);
    c = cyc; cc1 = 0; cc2 = 0;
    expect_at(c + 1, W_ST, 1, "R6 audio removed");
    wait_until(c + 3);
    c = cyc; cc1 = 3'd1; cc2 = 3'd1;
    expect_at(c + LCC + 1, W_ST, 11, "R6 debug");
    expect_at(c + LCC + 1, W_PT, 4, "R6 debug port");
    wait_until(c + LCC + 4);
    c = cyc; cc1 = 0; cc2 = 0;
    expect_at(c + 1, W_ST, 1, "R6 debug removed");
    wait_until(c + 3);
    c = cyc; acc = 0; cc1 = 3'd1; cc2 = 3'd1;
    expect_at(c + LCC + 3, W_ST, 3, "R6 disabled ignored");
    expect_at(c + LCC + 3, W_PT, 0, "R6 disabled port");
    drain();

    // R7: preference for source, sink found in trial
    do_reset(2'd2, 2'd2, 1'b0, c0);
    wait_until(c0 + 2);
    c = cyc; cc1 = 3'd3; vbus = 1;
    k = c + 1 + LCC;
    expect_at(k, W_ST, 6, "R7 trial src");
    wait_until(k); cc1 = 3'd1; vbus = 0;
    expect_at(k + LPD - 1, W_ST, 6, "R7 trial hold");
    expect_at(k + LPD, W_ST, 5, "R7 trial to src");
    drain();

    // R7: trial timeout, then sink attach from trial-wait
    do_reset(2'd2, 2'd2, 1'b0, c0);
    wait_until(c0 + 2);
    c = cyc; cc1 = 3'd3; vbus = 1;
    k = c + 1 + LCC; k2 = k + LTRY;
    expect_at(k2 - 1, W_ST, 6, "R7 before timeout");
    expect_at(k2, W_ST, 8, "R7 trial wait snk");
    expect_at(k2 + LCC - 1, W_ST, 8, "R7 wait debounce");
    expect_at(k2 + LCC, W_ST, 4, "R7 to snk");
    drain();

    // R8: preference for sink, source found in trial
    do_reset(2'd2, 2'd1, 1'b0, c0);
    wait_until(c0 + LTOG + 1);
    c = cyc; cc1 = 3'd1;
    k = c + 1 + LCC;
    expect_at(k, W_ST, 7, "R8 trial snk");
    wait_until(k); cc1 = 3'd5; vbus = 1;
    expect_at(k + LPD - 1, W_ST, 7, "R8 trial hold");
    expect_at(k + LPD, W_ST, 4, "R8 trial to snk");
    drain();

    // R8: timeout, sink still there in trial-wait
    do_reset(2'd2, 2'd1, 1'b0, c0);
    wait_until(c0 + LTOG + 1);
    c = cyc; cc1 = 3'd1;
    k = c + 1 + LCC; k2 = k + LTRY;
    expect_at(k2, W_ST, 9, "R8 trial wait src");
    expect_at(k2 + LPD, W_ST, 5, "R8 wait to src");
    drain();

    // R8: timeout, nothing in trial-wait
    do_reset(2'd2, 2'd1, 1'b0, c0);
    wait_until(c0 + LTOG + 1);
    c = cyc; cc1 = 3'd1;
    k = c + 1 + LCC; k2 = k + LTRY;
    wait_until(k); cc1 = 3'd0;
    expect_at(k2, W_ST, 9, "R8 trial wait empty");
    expect_at(k2 + LPD - 1, W_ST, 9, "R8 wait hold");
    expect_at(k2 + LPD, W_ST, 0, "R8 back to sink");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule